// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a small synchronous memory of 36-bit words, each word split into four lanes of nine bits. A request (address, read or write, per-lane write enables) is registered on one rising edge. The data transfer for that request takes place two active edges later. For a read, the word appears on the output register. For a write, the word is taken from the bus input at that edge and stored. Because reads and writes sit in the same two-stage slot, the bus can change direction on every cycle with no idle cycles between them.

An upstream burst sequencer supplies a finished address and a valid flag each cycle. Ordering of burst beats is the sequencer's job. The request path has no back-pressure: a request presented with the valid flag high is taken on every active edge. The only way to hold the requester off is the active-low clock enable. While it is high, every pipeline stage, the array and the outputs keep their values, and the presented request is dropped. Three chip-select pins must all agree for a request to be taken. A request made while deselected becomes an empty slot, but requests already in flight still finish. The bidirectional data pins are modelled as a separate input, an output, and a drive enable. An asynchronous active-low output enable gates the drive enable.

Top module: `zbt_sram`

## Requirements
- R1: A read request sampled at active edge k drives bus_oe high and bus_out with the addressed word after active edge k+2, and not after edge k+1.
- R2: A write request sampled at active edge k stores the bus_in value present at active edge k+2.
- R3: Reads and writes may be issued on consecutive active edges in any mix, with no idle cycle between them, and every read returns the correct word.
- R4: byte_we_n bit i low on a write stores bus_in bits [9i+8:9i] into lane i; lanes whose bit is high keep their old contents.
- R5: byte_we_n is ignored for reads; a read never changes the array, whatever the lane enables are.
- R6: After the edge at which a write or an empty slot (idle or deselected) leaves stage two, bus_oe is low.
- R7: Requests already taken before a deselect still complete (reads drive, writes store) on their normal cycles.
- R8: oe_n high forces bus_oe low at once, without a clock edge, and does not disturb the pipeline; lowering it restores drive.
- R9: With cken_n high at an edge, no stage, array word or output changes, and the request presented at that edge is dropped.
- R10: A request is taken only when sel_a_n = 0, sel_b_n = 0 and sel_c = 1; otherwise it becomes an empty slot and changes nothing.
- R11: After reset, bus_oe is low, bus_out is zero and the pipeline holds no request.
- R12: A read issued on the edge after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cken_n | input | 1 | Clock enable, active low; high freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| req_valid | input | 1 | A request is presented this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| byte_we_n | input | LANES | Per-lane write enables, active low |
| bus_in | input | LANES*LANE_W | Data bus input, sampled two edges after a write request |
| oe_n | input | 1 | Asynchronous output enable, active low |
| bus_out | output | LANES*LANE_W | Registered read data |
| bus_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench probes the exact latency of both directions. A design that is one cycle early or late drives data on the wrong cycle, or stores the filler value the bench puts on bus_in outside write slots. Streams of alternating reads and writes, and read-after-write to the same address, expose a design that needs a dead cycle or returns stale words. Partial-lane writes and reads with arbitrary lane enables catch lane decoding and corrupting reads. Stalls taken with a read in flight, deselects that follow pending transfers, and output-enable toggles in the middle of a drive window catch a pipeline that leaks through a stall, cancels work already taken, or lets the output enable reach the registers.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  // Kind of operation held in a pipeline slot
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // All three selects must agree for a request to be taken
  function automatic logic chip_selected(input logic a_n, input logic b_n, input logic c);
    return ~a_n & ~b_n & c;
  endfunction

endpackage

// File: rtl/zbt_ctrl_pipe.sv
module zbt_ctrl_pipe
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  byte_we_n,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_lane_we
);

  localparam int STAGES = 2;

  op_e               op_q   [STAGES];
  logic [ADDR_W-1:0] addr_q [STAGES];
  logic [LANES-1:0]  we_q   [STAGES];

  logic              sel;
  op_e               op_in;
  logic [LANES-1:0]  we_in;

  always_comb begin
    sel   = chip_selected(sel_a_n, sel_b_n, sel_c);
    op_in = OP_NONE;
    if (req_valid && sel) op_in = req_wr ? OP_WR : OP_RD;
    // lane enables only mean something on writes
    we_in = (op_in == OP_WR) ? ~byte_we_n : '0;
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            op_q[0]   <= OP_NONE;
            addr_q[0] <= '0;
            we_q[0]   <= '0;
          end else if (adv) begin
            op_q[0]   <= op_in;
            addr_q[0] <= req_addr;
            we_q[0]   <= we_in;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            op_q[s]   <= OP_NONE;
            addr_q[s] <= '0;
            we_q[s]   <= '0;
          end else if (adv) begin
            op_q[s]   <= op_q[s-1];
            addr_q[s] <= addr_q[s-1];
            we_q[s]   <= we_q[s-1];
          end
        end
      end
    end
  endgenerate

  assign s2_op      = op_q[STAGES-1];
  assign s2_addr    = addr_q[STAGES-1];
  assign s2_lane_we = we_q[STAGES-1];

  // R10
  desel_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && req_valid && !(~sel_a_n & ~sel_b_n & sel_c)) |=> (op_q[0] == OP_NONE));

  // R9
  ctrl_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(op_q[0]) && $stable(op_q[1]) && $stable(addr_q[1])));

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    adv,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
        if (adv && wr_en && lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end
  endgenerate

endmodule

// File: rtl/zbt_read_port.sv
module zbt_read_port #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              oe_n,
  output logic [DATA_W-1:0] bus_out,
  output logic              rd_drive,
  output logic              bus_oe
);

  logic [DATA_W-1:0] dq;
  logic              drive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq      <= '0;
      drive_q <= 1'b0;
    end else if (adv) begin
      drive_q <= rd_fire;
      if (rd_fire) dq <= rd_word;
    end
  end

  assign bus_out  = dq;
  assign rd_drive = drive_q;
  assign bus_oe   = drive_q & ~oe_n;

  // R9
  out_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(dq) && $stable(drive_q)));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cken_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic                    req_valid,
  input  logic                    req_wr,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES-1:0]        byte_we_n,
  input  logic [LANES*LANE_W-1:0] bus_in,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] bus_out,
  output logic                    bus_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic              adv;
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lane_we;
  logic [DATA_W-1:0] arr_rdata;
  logic              rd_drive;

  assign adv = ~cken_n;

  zbt_ctrl_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .sel_a_n    (sel_a_n),
    .sel_b_n    (sel_b_n),
    .sel_c      (sel_c),
    .req_valid  (req_valid),
    .req_wr     (req_wr),
    .req_addr   (req_addr),
    .byte_we_n  (byte_we_n),
    .s2_op      (s2_op),
    .s2_addr    (s2_addr),
    .s2_lane_we (s2_lane_we)
  );

  zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .adv     (adv),
    .wr_en   (s2_op == OP_WR),
    .addr    (s2_addr),
    .lane_we (s2_lane_we),
    .wdata   (bus_in),
    .rdata   (arr_rdata)
  );

  zbt_read_port #(.DATA_W(DATA_W)) u_rport (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .rd_fire  (s2_op == OP_RD),
    .rd_word  (arr_rdata),
    .oe_n     (oe_n),
    .bus_out  (bus_out),
    .rd_drive (rd_drive),
    .bus_oe   (bus_oe)
  );

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_op == OP_RD) |=> rd_drive);

  // R6
  turn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_op != OP_RD) |=> !rd_drive);

  // R8
  always_comb begin
    if (rst_n && oe_n) oe_gate_chk: assert (!bus_oe);
  end

endmodule

// File: tb/zbt_sram_bench.sv
module zbt_sram_bench;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, cken_n, sel_a_n, sel_b_n, sel_c;
  logic          req_valid, req_wr, oe_n, bus_oe;
  logic [AW-1:0] req_addr;
  logic [LN-1:0] byte_we_n;
  logic [DW-1:0] bus_in, bus_out;

  zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_zbt_sram (
    .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .sel_c(sel_c), .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr),
    .byte_we_n(byte_we_n), .bus_in(bus_in), .oe_n(oe_n), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  typedef struct {
    bit            v;
    bit            wr;
    int            addr;
    logic [LN-1:0] be_n;
    logic [DW-1:0] wd;
  } op_t;

  int            n_chk = 0;
  int            n_bad = 0;
  string         cur = "R11";
  op_t           p1, p2;
  logic [DW-1:0] model [1<<AW];
  bit            exp_drive = 0;
  logic [DW-1:0] exp_q = '0;
  int            rot = 0;
  bit            done = 0;

  task automatic check(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur, what, act, exp);
    end
  endtask

  // One clock: drive the request, feed bus_in for the write in stage two, then check outputs
  task automatic cyc(bit stall, bit v, bit sel_ok, bit wr, int addr,
                     logic [LN-1:0] be_n, logic [DW-1:0] wd);
    op_t n;
    cken_n    = stall;
    req_valid = v;
    req_wr    = wr;
    req_addr  = addr[AW-1:0];
    byte_we_n = be_n;
    sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b1;
    if (!sel_ok) begin
      case (rot % 3)
        0: sel_a_n = 1'b1;
        1: sel_b_n = 1'b1;
        default: sel_c = 1'b0;
      endcase
      rot++;
    end
    bus_in = (p2.v && p2.wr) ? p2.wd : 36'h5A5_A5A5_A5;
    @(posedge clk);
    @(negedge clk);
    if (!stall) begin
      if (p2.v && p2.wr)
        for (int i = 0; i < LN; i++)
          if (!p2.be_n[i]) model[p2.addr][i*LW +: LW] = p2.wd[i*LW +: LW];
      exp_drive = p2.v && !p2.wr;
      if (exp_drive) exp_q = model[p2.addr];
      p2     = p1;
      n.v    = v && sel_ok;
      n.wr   = wr;
      n.addr = addr;
      n.be_n = be_n;
      n.wd   = wd;
      p1     = n;
    end
    check("bus_oe", DW'(bus_oe), DW'(exp_drive && !oe_n));
    check("bus_out", bus_out, exp_q);
  endtask

  task automatic wr_op(int a, logic [DW-1:0] d, logic [LN-1:0] be = '0);
    cyc(0, 1, 1, 1, a, be, d);
  endtask
  task automatic rd_op(int a, logic [LN-1:0] be = '1);
    cyc(0, 1, 1, 0, a, be, '0);
  endtask
  task automatic idle();
    cyc(0, 0, 1, 0, 0, '1, '0);
  endtask
  task automatic flush();
    idle(); idle();
  endtask

  task automatic t_reset();
    cur = "R11";
    check("bus_oe", DW'(bus_oe), '0);
    check("bus_out", bus_out, '0);
  endtask

  task automatic t_latency();
    cur = "R2";
    wr_op(5, 36'h1_2345_6789);
    flush();
    cur = "R1";
    rd_op(5);
    idle();   // one edge later the bus must still be off
    idle();   // two edges later the word is driven
    cur = "R6";
    wr_op(6, 36'hF_0F0F_0F0F);
    idle();
    idle();   // write leaves stage two: bus off
  endtask

  task automatic t_pingpong();
    cur = "R3";
    wr_op(10, 36'hA_0000_0010);
    wr_op(11, 36'hA_0000_0011);
    rd_op(10);
    wr_op(12, 36'hA_0000_0012);
    rd_op(11);
    wr_op(13, 36'hA_0000_0013);
    rd_op(12);
    rd_op(13);
    wr_op(10, 36'hB_1111_1110);
    rd_op(10);
    flush();
  endtask

  task automatic t_raw();
    cur = "R12";
    wr_op(20, 36'h3_3333_3333);
    rd_op(20);
    wr_op(20, 36'h4_4444_4444);
    rd_op(20);
    flush();
  endtask

  task automatic t_bytes();
    cur = "R4";
    wr_op(30, 36'h0_0000_0000);
    wr_op(31, 36'hF_FFFF_FFFF);
    wr_op(30, 36'hF_FFFF_FFFF, 4'b1010);
    wr_op(31, 36'h0_0000_0000, 4'b0111);
    rd_op(30);
    rd_op(31);
    flush();
  endtask

  task automatic t_rd_be();
    cur = "R5";
    rd_op(30, 4'b0000);
    rd_op(31, 4'b0101);
    rd_op(30, 4'b1111);
    rd_op(31, 4'b0000);
    flush();
  endtask

  task automatic t_desel();
    cur = "R7";
    wr_op(40, 36'h7_7777_0040);
    rd_op(30);
    cyc(0, 1, 0, 1, 40, '0, 36'hE_EEEE_EEEE);
    cyc(0, 1, 0, 0, 40, '0, '0);
    cur = "R10";
    cyc(0, 1, 0, 1, 40, '0, 36'hD_DDDD_DDDD);
    cyc(0, 1, 0, 1, 40, '0, 36'hD_DDDD_DDDD);
    cyc(0, 1, 0, 1, 40, '0, 36'hD_DDDD_DDDD);
    cur = "R6";
    idle();
    cur = "R10";
    rd_op(40);
    flush();
  endtask

  task automatic t_stall();
    cur = "R9";
    wr_op(41, 36'h9_0000_0041);
    flush();
    rd_op(40);
    cyc(1, 1, 1, 1, 41, '0, 36'h6_6666_6666);  // dropped request
    cyc(1, 0, 1, 0, 0, '1, '0);
    idle();
    cyc(1, 1, 1, 0, 30, '1, '0);
    cyc(1, 0, 1, 0, 0, '1, '0);
    idle();   // read of 40 emerges now
    cyc(1, 0, 1, 0, 0, '1, '0);
    rd_op(41);
    flush();
  endtask

  task automatic t_oe();
    cur = "R8";
    rd_op(30);
    idle();
    idle();
    oe_n = 1'b1;
    #1 check("bus_oe async off", DW'(bus_oe), '0);
    oe_n = 1'b0;
    #1 check("bus_oe async on", DW'(bus_oe), 1);
    rd_op(31);
    idle();
    oe_n = 1'b1;
    idle();   // read retires while output enable is high
    oe_n = 1'b0;
    #1 check("bus_oe restored", DW'(bus_oe), 1);
    check("bus_out held", bus_out, model[31]);
    flush();
  endtask

  initial begin
    p1 = '{default: 0};
    p2 = '{default: 0};
    rst_n = 1'b0; cken_n = 1'b0; sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b1;
    req_valid = 1'b0; req_wr = 1'b0; req_addr = '0; byte_we_n = '1;
    bus_in = '0; oe_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_pingpong();
    t_raw();
    t_bytes();
    t_rd_be();
    t_desel();
    t_stall();
    t_oe();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule